// File: doc/BRIEF.md
# Rotary Encoder Frequency Step Control

This block turns the two phase outputs of a mechanical rotary encoder into changes of a 16-bit tuning word for a direct digital synthesiser. Both phases pass through a two-stage synchroniser. A slow poll strobe then clocks a small table-driven state machine. The state code is always a multiple of four. It is combined with the 2-bit pin value to select the next code. Two low bits in that code mark one step in either direction, and one reserved code marks a transition that cannot occur.

Each clockwise step adds a fixed amount to the tuning word and each counter-clockwise step subtracts it, both modulo 2^16. Whenever the word moves, a one-cycle pulse asks the display path to recompute the shown frequency. After an impossible transition the block makes no step and takes a fresh state from the present pin levels, so it recovers without a reset.

Top module: `enc_tune_ctrl`

## Requirements
- R1: After reset the tuning word equals the INIT_WORD parameter, the change pulse is low and the decoder is in its rest state (code 0x00).
- R2: The decoder advances only in cycles where poll_en is high. It uses the pin levels after the two synchroniser flops, so a pin change in the cycle before a poll is not yet seen, and pin changes between polls have no effect on the outputs.
- R3: The pin value is {enc_b, enc_a}. From rest, value 00 keeps rest, 01 enters code 0x04, 10 enters code 0x08, and 11 is an impossible transition.
- R4: The pin sequence 00, 01, 11, 10, 00 gives two clockwise steps. The first step is at 11 (from code 0x04) and the second is on the return to 00 (from code 0x1C). Each step adds STEP (default 20) to the tuning word.
- R5: The pin sequence 00, 10, 11, 01, 00 gives two counter-clockwise steps. The first step is at 11 (from code 0x08) and the second is on the return to 00 (from code 0x18). Each step subtracts STEP.
- R6: Addition and subtraction wrap around modulo 2^16.
- R7: tune_changed is high for exactly the one cycle after a poll edge that changed the tuning word, and it is low at all other times.
- R8: An impossible transition changes nothing at the outputs and reloads the state code with the synchronised pins at bits 3:2. With pins 11 this gives code 0x0C, from which 01 then 00 gives a counter-clockwise step. With pins 10 this gives code 0x08, from which 11 gives a counter-clockwise step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| poll_en | input | 1 | One-cycle strobe that evaluates the decoder |
| tune_word | output | 16 | Tuning word |
| tune_changed | output | 1 | One-cycle pulse after the tuning word changes |

## Verification
A pin edge and the poll strobe can arrive in the same cycle. The bench provokes this by moving both pins to 11 and raising poll_en on the very next edge. A correct synchroniser hides the new value, so the decoder stays at rest, and the following polls at 10 and then 11 must give a counter-clockwise step. Had the fresh value been seen, the error reload to code 0x0C would have swallowed that step.

// File: rtl/enc_tune_ctrl.sv
module enc_tune_ctrl #(
  parameter int WIDTH     = 16,
  parameter int STEP      = 20,
  parameter int INIT_WORD = 328
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             poll_en,
  output logic [WIDTH-1:0] tune_word,
  output logic             tune_changed
);
  localparam logic [5:0] BAD = 6'h3C;
  localparam logic [WIDTH-1:0] STEP_W = WIDTH'(STEP);

  logic [1:0] sync_a, sync_b;
  logic [5:0] state, code;
  logic [1:0] pins;

  assign pins = {sync_b[1], sync_a[1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= {sync_a[0], enc_a};
      sync_b <= {sync_b[0], enc_b};
    end
  end

  always_comb begin
    code = BAD;
    case ({state[5:2], pins})
      6'h00: code = 6'h00;  6'h01: code = 6'h04;  6'h02: code = 6'h08;  6'h03: code = BAD;
      6'h04: code = 6'h00;  6'h05: code = 6'h04;  6'h06: code = BAD;    6'h07: code = 6'h12;
      6'h08: code = 6'h00;  6'h09: code = BAD;    6'h0A: code = 6'h08;  6'h0B: code = 6'h15;
      6'h0C, 6'h10, 6'h14: code = BAD;
      6'h0D, 6'h11, 6'h15: code = 6'h18;
      6'h0E, 6'h12, 6'h16: code = 6'h1C;
      6'h0F, 6'h13, 6'h17: code = 6'h0C;
      6'h18: code = 6'h21;  6'h19: code = 6'h18;  6'h1A: code = BAD;    6'h1B: code = 6'h0C;
      6'h1C: code = 6'h26;  6'h1D: code = BAD;    6'h1E: code = 6'h1C;  6'h1F: code = 6'h0C;
      6'h20, 6'h24: code = 6'h00;
      6'h21, 6'h25: code = 6'h04;
      6'h22, 6'h26: code = 6'h08;
      default: code = BAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= '0;
      tune_word    <= WIDTH'(INIT_WORD);
      tune_changed <= 1'b0;
    end else begin
      tune_changed <= 1'b0;
      if (poll_en) begin
        if (code == BAD) begin
          state <= {2'b00, pins, 2'b00};
        end else begin
          state <= {code[5:2], 2'b00};
          if (code[1]) tune_word <= tune_word + STEP_W;
          else if (code[0]) tune_word <= tune_word - STEP_W;
          tune_changed <= code[1] | code[0];
        end
      end
    end
  end

  assert_step_size_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    tune_changed |-> (tune_word == $past(tune_word) + STEP_W ||
                      tune_word == $past(tune_word) - STEP_W));
  assert_change_flagged_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tune_word) |-> tune_changed);
  assert_poll_only_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    tune_changed |-> $past(poll_en));
  assert_state_legal_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    state[1:0] == 2'b00 && state <= 6'h24);
  assert_hold_unpolled_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    !poll_en |=> $stable(state));
endmodule

// File: tb/test_enc_tune_ctrl.sv
module test_enc_tune_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int INIT = 10;
  localparam int STEP = 20;

  logic clk = 0, rst_n = 0, enc_a = 0, enc_b = 0, poll_en = 0;
  logic [15:0] tune_word;
  logic tune_changed;
  int checks = 0, errors = 0;
  logic [15:0] exp_tw = 16'(INIT);
  logic allow_chg = 0;
  logic [16:0] exp_q[$];
  string tag_q[$];
  event item_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  enc_tune_ctrl #(.WIDTH(16), .STEP(STEP), .INIT_WORD(INIT)) i_enc_tune_ctrl (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .poll_en(poll_en),
    .tune_word(tune_word), .tune_changed(tune_changed));

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got word=%0d chg=%0b, expected word=%0d chg=%0b",
               tag, act[15:0], act[16], exp[15:0], exp[16]);
    end
  endtask

  // monitor: pops expected items and compares with the outputs
  initial forever begin
    @(item_ev);
    while (exp_q.size() > 0) begin
      logic [16:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {tune_changed, tune_word}, e);
    end
  end

  // R7: no pulse outside a poll window
  always @(negedge clk) begin
    if (rst_n && !allow_chg && tune_changed === 1'b1) begin
      checks++; errors++;
      $display("FAIL R7: spurious tune_changed, got 1 expected 0");
    end
  end

  task automatic poll_and_push(input int dir, input string tag);
    poll_en = 1; allow_chg = 1;
    @(posedge clk); @(negedge clk);
    poll_en = 0;
    exp_tw = exp_tw + 16'(dir * STEP);
    exp_q.push_back({dir != 0, exp_tw});
    tag_q.push_back(tag);
    -> item_ev;
    @(posedge clk); @(negedge clk);
    allow_chg = 0;
  endtask

  task automatic step(input logic b, input logic a, input int dir, input string tag);
    enc_b = b; enc_a = a;
    @(posedge clk); @(posedge clk); @(negedge clk);
    poll_and_push(dir, tag);
  endtask

  task automatic quick_poll(input logic b, input logic a, input string tag);
    enc_b = b; enc_a = a;
    poll_and_push(0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {tune_changed, tune_word}, {1'b0, 16'(INIT)});
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", {tune_changed, tune_word}, {1'b0, 16'(INIT)});
    step(0, 0, 0, "R3 rest stays");
    // R5 counter-clockwise full cycle, with R6 downward wrap
    step(1, 0, 0, "R5 enter 0x08");
    step(1, 1, -1, "R5 first ccw R6 wrap");
    step(0, 1, 0, "R5 mid");
    step(0, 0, -1, "R5 second ccw");
    // R4 clockwise full cycle, with R6 upward wrap
    step(0, 1, 0, "R4 enter 0x04");
    step(1, 1, 1, "R4 first cw");
    step(1, 0, 0, "R4 mid");
    step(0, 0, 1, "R4 second cw R6 wrap");
    step(0, 1, 0, "R4 again");
    step(1, 1, 1, "R4 cw");
    step(1, 0, 0, "R4 mid");
    step(0, 0, 1, "R4 cw return");
    // R8 illegal from rest with pins 11 reloads 0x0C
    step(1, 1, 0, "R3 R8 illegal no step");
    step(0, 1, 0, "R8 from 0x0C");
    step(0, 0, -1, "R8 ccw after reload 11");
    // R8 illegal from 0x04 with pins 10 reloads 0x08
    step(0, 1, 0, "R8 enter 0x04");
    step(1, 0, 0, "R8 illegal no step");
    step(1, 1, -1, "R8 ccw after reload 10");
    step(0, 1, 0, "R5 mid");
    step(0, 0, -1, "R5 back to rest");
    // R2 pin movement without polls has no effect
    enc_b = 0; enc_a = 1; repeat (6) @(posedge clk);
    enc_b = 1; enc_a = 1; repeat (6) @(posedge clk);
    enc_b = 1; enc_a = 0; repeat (6) @(posedge clk);
    @(negedge clk);
    step(0, 0, 0, "R2 unpolled movement ignored");
    // R2 synchroniser: poll right after a pin edge sees old value
    quick_poll(1, 1, "R2 fresh edge not seen");
    step(1, 0, 0, "R2 enter 0x08");
    step(1, 1, -1, "R2 ccw proves rest kept");
    step(0, 1, 0, "R5 mid");
    step(0, 0, -1, "R5 return");
    repeat (4) @(negedge clk);
    check("R7 idle pulse low", {tune_changed, tune_word}, {1'b0, exp_tw});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule